// File: doc/BRIEF.md
# Event Timestamp Snapshot Capture

This block records the value of a free-running 64-bit system time bus each time an external trigger line goes from low to high. The trigger is asynchronous to the block clock. It passes through a two-stage synchronizer and then a rising-edge detector. Each detected edge writes one entry into a 16-deep first-in first-out store. An entry holds the 64-bit time and a source tag. Only one trigger input exists, so every entry carries tag 0. The tag field is still stored so that the source of the head entry can be reported.

The host reads the block through a small register port. It reads a status word first. The status word gives the fill level, a sticky overflow flag and the source tag of the head entry. The host then reads the head timestamp as two 32-bit words: first the low word, then the high word. Reading the high word removes the entry. An interrupt level stays asserted while at least one entry is stored.

Top module: `ts_snap_capture`

## Requirements
- R1: The block makes one capture per low-to-high transition of `trig_i`. A trigger held high makes no further captures. Suppose `trig_i` is first sampled high at rising edge k, after being sampled low at edge k-1. The stored time is then the `sys_time_i` value present just before edge k+2.
- R2: The store holds 16 entries and returns them in capture order. A capture that arrives while 16 entries are stored is dropped.
- R3: Each entry keeps the full 64-bit time and a 2-bit source tag. The tag is 0 for the single trigger input. The tag of the head entry reads in status bits [17:16], and reads 0 when the store is empty.
- R4: Register addresses are 0 for status, 1 for the time low word [31:0], 2 for the time high word [63:32], and 3 for reserved (reads 0). The status word holds the fill level in bits [7:0] and the overflow flag in bit 8; all other bits are 0. Read data appears on `rd_data_o` one cycle after `rd_en_i` and holds until the next read.
- R5: A read of address 2 while the store is not empty removes the head entry. Reads of other addresses never remove an entry. A read of address 1 or 2 while the store is empty returns 0 and changes nothing.
- R6: A dropped capture sets the overflow flag. The flag stays set until a status read, which returns the flag's value from before the clear. If a drop and a status read fall on the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly while the store holds at least one entry. It changes at the same clock edge as the capture or removal that changes the fill level.
- R8: After reset, the store is empty, the overflow flag is clear, `irq_o` is 0 and `rd_data_o` is 0.
- R9: Fullness is judged on the fill level before the clock edge. A capture on the same cycle as a high-word read of a full store is dropped, so the level becomes 15 and overflow is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_time_i | input | 64 | Running system time, synchronous to clk_i |
| trig_i | input | 1 | Asynchronous capture trigger |
| rd_en_i | input | 1 | Register read strobe, one cycle per read |
| rd_addr_i | input | 2 | Register address |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Capture interrupt, level while entries are stored |

## Verification
Each result has its own latency.
- A trigger first sampled high at edge k affects the stored entries, the fill level and `irq_o` at edge k+2.
- Read data, a removal and an overflow clear all take effect at the edge that samples the read strobe.

The bench keeps a behavioural model that it advances on every rising edge, using the inputs the bench set at the previous falling edge. It then compares `rd_data_o` and `irq_o` at the next falling edge, so each result is sampled in the first cycle in which it is due. Directed sequences place a trigger edge two cycles before a high-word read or a status read. This makes a capture and the read land on the same edge, which exercises the full-store drop and the overflow set-over-clear case.

// File: rtl/ts_snap_pkg.sv
package ts_snap_pkg;

    // register addresses
    localparam logic [1:0] ADDR_STATUS  = 2'd0;
    localparam logic [1:0] ADDR_TIME_LO = 2'd1;
    localparam logic [1:0] ADDR_TIME_HI = 2'd2;

    // status field positions
    localparam int ST_LEVEL_LSB = 0;
    localparam int ST_LEVEL_W   = 8;
    localparam int ST_OVF_BIT   = 8;
    localparam int ST_TAG_LSB   = 16;

    localparam int REG_W = 32;

endpackage

// File: rtl/ts_trig_edge.sv
module ts_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rise_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb begin
                s_d      = s_q;
                s_d.sync = trig_i;
                s_d.prev = s_q.sync[0];
            end
        end else begin : g_chain
            always_comb begin
                s_d      = s_q;
                s_d.sync = {s_q.sync[SYNC_STAGES-2:0], trig_i};
                s_d.prev = s_q.sync[SYNC_STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.sync[SYNC_STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/ts_snap_fifo.sv
module ts_snap_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 66,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              full_o,
    output logic              empty_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         s_d, s_q;
    logic             do_push, do_pop;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        s_d     = s_q;
        full_o  = (s_q.cnt == FULL_CNT);
        empty_o = (s_q.cnt == '0);
        do_push = push_i & ~full_o;
        do_pop  = pop_i & ~empty_o;
        if (do_push) begin
            s_d.wr = (s_q.wr == LAST_PTR) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == LAST_PTR) ? '0 : s_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) begin
            mem_q[s_q.wr] <= push_data_i;
        end
    end

    assign head_o  = mem_q[s_q.rd];
    assign level_o = s_q.cnt;

endmodule

// File: rtl/ts_snap_regs.sv
module ts_snap_regs
    import ts_snap_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int TAG_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    input  logic [TIME_W-1:0] head_time_i,
    input  logic [TAG_W-1:0]  head_tag_i,
    input  logic [CNT_W-1:0]  level_i,
    input  logic              empty_i,
    input  logic              drop_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              pop_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [REG_W-1:0] rd_data;
        logic             ovf;
    } reg_st_t;

    reg_st_t          s_d, s_q;
    logic [REG_W-1:0] status_w;

    always_comb begin
        s_d      = s_q;
        status_w = '0;
        status_w[ST_LEVEL_LSB +: CNT_W] = level_i;
        status_w[ST_OVF_BIT]            = s_q.ovf;
        status_w[ST_TAG_LSB +: TAG_W]   = empty_i ? '0 : head_tag_i;
        pop_o    = 1'b0;

        if (rd_en_i) begin
            case (rd_addr_i)
                ADDR_STATUS: begin
                    s_d.rd_data = status_w;
                    s_d.ovf     = 1'b0;
                end
                ADDR_TIME_LO: begin
                    s_d.rd_data = empty_i ? '0 : head_time_i[REG_W-1:0];
                end
                ADDR_TIME_HI: begin
                    s_d.rd_data = empty_i ? '0 : head_time_i[2*REG_W-1:REG_W];
                    pop_o       = ~empty_i;
                end
                default: s_d.rd_data = '0;
            endcase
        end
        // a drop on the same cycle as a status read keeps the flag set
        if (drop_i) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o = s_q.rd_data;
    assign ovf_o     = s_q.ovf;

endmodule

// File: rtl/ts_snap_capture.sv
module ts_snap_capture
    import ts_snap_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int DEPTH       = 16,
    parameter int TAG_W       = 2,
    parameter int SRC_ID      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] sys_time_i,
    input  logic              trig_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);

    localparam int ENTRY_W = TAG_W + TIME_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam logic [TAG_W-1:0] SRC_TAG = TAG_W'(SRC_ID);

    logic               rise;
    logic               pop;
    logic               ovf;
    logic               fifo_full;
    logic               fifo_empty;
    logic [CNT_W-1:0]   fifo_level;
    logic [ENTRY_W-1:0] entry_in;
    logic [ENTRY_W-1:0] entry_head;
    logic               drop;

    ts_trig_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    always_comb begin
        entry_in = {SRC_TAG, sys_time_i};
        drop     = rise & fifo_full;
    end

    ts_snap_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (ENTRY_W)
    ) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (rise),
        .push_data_i (entry_in),
        .pop_i       (pop),
        .head_o      (entry_head),
        .level_o     (fifo_level),
        .full_o      (fifo_full),
        .empty_o     (fifo_empty)
    );

    ts_snap_regs #(
        .TIME_W (TIME_W),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rd_en_i     (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .head_time_i (entry_head[TIME_W-1:0]),
        .head_tag_i  (entry_head[ENTRY_W-1:TIME_W]),
        .level_i     (fifo_level),
        .empty_i     (fifo_empty),
        .drop_i      (drop),
        .rd_data_o   (rd_data_o),
        .pop_o       (pop),
        .ovf_o       (ovf)
    );

    assign irq_o = ~fifo_empty;

endmodule

// File: rtl/ts_snap_capture_chk.sv
module ts_snap_capture_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rise_i,
    input logic             full_i,
    input logic             pop_i,
    input logic             ovf_i,
    input logic [CNT_W-1:0] level_i,
    input logic             rd_en_i,
    input logic [1:0]       rd_addr_i,
    input logic             irq_i
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_LESS = CNT_W'(DEPTH - 1);

    // R1
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> !rise_i);

    // R2
    level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_i <= FULL_CNT);

    // R5
    no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_addr_i != 2'd2 && !rise_i) |=> level_i == $past(level_i));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_i && !(rd_en_i && rd_addr_i == 2'd0)) |=> ovf_i);

    // R6
    ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && full_i) |=> ovf_i);

    // R7
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> $past(rise_i));

    // R7
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_i) |-> $past(pop_i));

    // R9
    full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_i && rise_i && pop_i) |=> level_i == ONE_LESS);

endmodule

bind ts_snap_capture ts_snap_capture_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .full_i    (fifo_full),
    .pop_i     (pop),
    .ovf_i     (ovf),
    .level_i   (fifo_level),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .irq_i     (irq_o)
);

// File: tb/tb_ts_snap_capture.sv
module tb_ts_snap_capture;

    localparam int CLK_P = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] sys_time_i = 64'hA5A5_0001_FFFF_FF00;
    logic        trig_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_addr_i = 2'd0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R8";

    // behavioural reference state
    logic [63:0] tq[$];
    logic [31:0] exp_rd = '0;
    bit          exp_ovf = 0;
    bit          h1 = 0, h2 = 0, h3 = 0;

    ts_snap_capture dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sys_time_i (sys_time_i),
        .trig_i     (trig_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .irq_o      (irq_o)
    );

    always #(CLK_P/2) clk_i = ~clk_i;

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            tq.delete();
            exp_rd = '0; exp_ovf = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit cap;
            int pre;
            cap = h2 && !h3;
            pre = tq.size();
            if (rd_en_i) begin
                case (rd_addr_i)
                    2'd0: exp_rd = 32'(pre) | (32'(exp_ovf) << 8);
                    2'd1: exp_rd = (pre > 0) ? tq[0][31:0] : 32'h0;
                    2'd2: exp_rd = (pre > 0) ? tq[0][63:32] : 32'h0;
                    default: exp_rd = 32'h0;
                endcase
                if (rd_addr_i == 2'd0) exp_ovf = 0;
                if (rd_addr_i == 2'd2 && pre > 0) void'(tq.pop_front());
            end
            if (cap) begin
                if (pre < 16) tq.push_back(sys_time_i);
                else exp_ovf = 1;
            end
            h3 = h2; h2 = h1; h1 = trig_i;
        end
    end

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_i);
        check(phase, "rd_data (R4)", 64'(rd_data_o), 64'(exp_rd));
        check("R7", "irq", 64'(irq_o), 64'(tq.size() != 0));
        sys_time_i = sys_time_i + 64'd7;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        rd_en_i = 1'b1; rd_addr_i = a;
        step();
        v = rd_data_o;
        rd_en_i = 1'b0;
    endtask

    task automatic pulse(input int hi, input int lo);
        trig_i = 1'b1;
        repeat (hi) step();
        trig_i = 1'b0;
        repeat (lo) step();
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk_i);
        check("R8", "reset rd_data", 64'(rd_data_o), 64'h0);
        check("R8", "reset irq", 64'(irq_o), 64'h0);
        rst_ni = 1'b1;
        step();
        rd_reg(2'd0, v);
        check("R8", "status after reset", 64'(v), 64'h0);

        // R1: long high level gives one capture
        phase = "R1";
        pulse(12, 6);
        rd_reg(2'd0, v);
        check("R1", "level after held trigger", 64'(v), 64'h1);
        check("R3", "head tag field", 64'(v[17:16]), 64'h0);
        phase = "R3";
        rd_reg(2'd1, v);
        rd_reg(2'd3, v);
        check("R4", "reserved address", 64'(v), 64'h0);
        rd_reg(2'd2, v);
        step();
        check("R7", "irq after last pop", 64'(irq_o), 64'h0);

        // R2: overfill with 18 short pulses
        phase = "R2";
        for (int i = 0; i < 18; i++) pulse(1, 3);
        rd_reg(2'd0, v);
        check("R2", "status full+ovf", 64'(v), 64'h110);
        rd_reg(2'd0, v);
        check("R6", "ovf cleared by status read", 64'(v), 64'h010);
        for (int i = 0; i < 16; i++) begin
            rd_reg(2'd1, v);
            rd_reg(2'd2, v);
        end
        phase = "R5";
        rd_reg(2'd1, v);
        check("R5", "empty low read", 64'(v), 64'h0);
        rd_reg(2'd2, v);
        check("R5", "empty high read", 64'(v), 64'h0);
        rd_reg(2'd0, v);
        check("R5", "status after drain", 64'(v), 64'h0);

        // R9: full store, capture and pop on the same edge
        phase = "R9";
        for (int i = 0; i < 16; i++) pulse(1, 2);
        trig_i = 1'b1;
        step();
        step();
        rd_en_i = 1'b1; rd_addr_i = 2'd2;
        step();
        rd_en_i = 1'b0; trig_i = 1'b0;
        step(); step();
        rd_reg(2'd0, v);
        check("R9", "level 15 and ovf after full drop", 64'(v), 64'h10F);

        // R6: drop and status read on the same edge
        phase = "R6";
        pulse(1, 4);
        trig_i = 1'b1;
        step();
        step();
        rd_en_i = 1'b1; rd_addr_i = 2'd0;
        step();
        v = rd_data_o;
        rd_en_i = 1'b0; trig_i = 1'b0;
        check("R6", "status read returns pre-edge flag", 64'(v), 64'h010);
        step(); step();
        rd_reg(2'd0, v);
        check("R6", "set wins over clear", 64'(v), 64'h110);
        for (int i = 0; i < 16; i++) begin
            rd_reg(2'd1, v);
            rd_reg(2'd2, v);
        end
        step();
        check("R7", "irq low after drain", 64'(irq_o), 64'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule